// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Snooze Compare

This block sequences a chip between four power modes: full run, halt, stop, and an intermediate snooze mode. It drives three gating controls: the CPU clock enable, the peripheral clock enable and the high-speed oscillator enable. The CPU requests halt or stop with single-cycle instruction strobes. Interrupts and reset bring the chip back to full run. Each mode has its own set of interrupt sources that can wake it.

While stopped, the block can wake partially when a serial receiver detects a start of reception or when a timer requests an ADC conversion. In snooze the oscillator and the peripherals run and the CPU clock stays gated. At the end of the snooze visit the peripheral sends a done strobe. The block then wakes the CPU fully or drops back to stop. For a serial visit the decision comes from the valid-reception flag. For an ADC visit it comes from the ADC window comparator in this block, which has four selectable criteria. The serial receiver, the converter and the CPU are outside the block.

Top module: `pwr_mode_top`

## Requirements
- R1: An active-low `rstN` puts the block in run asynchronously, from any mode and ahead of every other input. Run drives `cpuClkEn`, `periClkEn` and `oscEn` all high.
- R2: In run, `haltInstr` moves the block to halt on the next edge. Halt drives `cpuClkEn` low and keeps `periClkEn` and `oscEn` high.
- R3: In halt, any of `extIrq`, `wakeTmrIrq` or `periphIrq` returns the block to run on the next edge.
- R4: In run, `stopInstr` moves the block to stop, where all three enables are low. `stopInstr` wins when it arrives together with `haltInstr`.
- R5: In stop, `periphIrq`, `haltInstr` and `snoozeDone` have no effect, and all three enables stay low.
- R6: In stop, `extIrq` or `wakeTmrIrq` returns the block to run on the next edge. This takes priority over a snooze request in the same cycle.
- R7: In stop, `rxStartDet` or `adcTrig` moves the block to snooze, where `cpuClkEn` is low and `periClkEn` and `oscEn` are high. Snooze ignores interrupts until `snoozeDone` arrives.
- R8: When a serial snooze visit (entered by `rxStartDet`, which wins over `adcTrig`) ends on `snoozeDone`, the block goes to run if `rxValid` is high and back to stop otherwise.
- R9: When an ADC snooze visit ends on `snoozeDone`, the block goes to run if `cmpMatch` is high and back to stop otherwise. `rxValid` is ignored for this kind of visit.
- R10: `cmpMatch` is combinational from `adcResult` and depends on `cmpMode`. 00 means result < `adcLow`. 01 means result > `adcHigh`. 10 means `adcLow` <= result <= `adcHigh`. 11 means result < `adcLow` or result > `adcHigh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| haltInstr | input | 1 | Halt instruction strobe from the CPU |
| stopInstr | input | 1 | Stop instruction strobe from the CPU |
| extIrq | input | 1 | External interrupt |
| wakeTmrIrq | input | 1 | Interrupt from the low-speed wake timer |
| periphIrq | input | 1 | Interrupt from a high-speed-clocked peripheral |
| rxStartDet | input | 1 | Serial reception start detected |
| adcTrig | input | 1 | Timer-triggered ADC conversion request |
| snoozeDone | input | 1 | End of the snooze activity |
| rxValid | input | 1 | Received frame is valid |
| adcResult | input | 10 | Conversion result |
| adcLow | input | 10 | Lower compare limit |
| adcHigh | input | 10 | Upper compare limit |
| cmpMode | input | 2 | Compare criterion select |
| cmpMatch | output | 1 | Window compare result |
| cpuClkEn | output | 1 | CPU clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | High-speed oscillator enable |

## Verification
The properties assume that the strobes are synchronous to `clk` and stable around its edges. They also assume that `adcLow` is no greater than `adcHigh` whenever a window criterion is checked, and that `snoozeDone` matters only while the block is in snooze. The stimulus changes every input on the falling edge. It keeps the lower limit at or below the upper limit in every compare vector. It sends `snoozeDone` outside snooze only in the deliberate check that stop ignores it.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_HALT   = 2'd1,
    PM_STOP   = 2'd2,
    PM_SNOOZE = 2'd3
  } pmState_t;

  typedef enum logic [1:0] {
    CMP_BELOW   = 2'd0,
    CMP_ABOVE   = 2'd1,
    CMP_INSIDE  = 2'd2,
    CMP_OUTSIDE = 2'd3
  } cmpMode_t;

  // strobes from the sequencer to the snooze datapath
  typedef struct packed {
    logic enterSnz;
    logic srcAdc;
  } snzStrobe_t;

endpackage

// File: rtl/pwr_mode_cmp.sv
module pwr_mode_cmp
  import pwr_mode_pkg::*;
#(
  parameter int ADC_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  snzStrobe_t       strb,
  input  logic [ADC_W-1:0] adcResult,
  input  logic [ADC_W-1:0] adcLow,
  input  logic [ADC_W-1:0] adcHigh,
  input  logic [1:0]       cmpMode,
  input  logic             rxValid,
  output logic             cmpMatch,
  output logic             wakeOk
);

  logic     srcAdcQ;
  logic     belowLo;
  logic     aboveHi;
  cmpMode_t modeSel;

  assign modeSel = cmpMode_t'(cmpMode);
  assign belowLo = adcResult < adcLow;
  assign aboveHi = adcResult > adcHigh;

  always_comb begin
    unique case (modeSel)
      CMP_BELOW:   cmpMatch = belowLo;
      CMP_ABOVE:   cmpMatch = aboveHi;
      CMP_INSIDE:  cmpMatch = !belowLo && !aboveHi;
      CMP_OUTSIDE: cmpMatch = belowLo || aboveHi;
      default:     cmpMatch = 1'b0;
    endcase
  end

  // remember which peripheral opened the snooze visit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             srcAdcQ <= 1'b0;
    else if (strb.enterSnz) srcAdcQ <= strb.srcAdc;
  end

  assign wakeOk = srcAdcQ ? cmpMatch : rxValid;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltInstr,
  input  logic       stopInstr,
  input  logic       extIrq,
  input  logic       wakeTmrIrq,
  input  logic       periphIrq,
  input  logic       rxStartDet,
  input  logic       adcTrig,
  input  logic       snoozeDone,
  input  logic       wakeOk,
  output snzStrobe_t strb,
  output logic       cpuClkEn,
  output logic       periClkEn,
  output logic       oscEn
);

  pmState_t state;
  pmState_t nextState;
  logic     lowSpeedWake;

  assign lowSpeedWake = extIrq || wakeTmrIrq;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      PM_RUN: begin
        if (stopInstr)      nextState = PM_STOP;
        else if (haltInstr) nextState = PM_HALT;
      end
      PM_HALT: begin
        if (lowSpeedWake || periphIrq) nextState = PM_RUN;
      end
      PM_STOP: begin
        if (lowSpeedWake) begin
          nextState = PM_RUN;
        end else if (rxStartDet || adcTrig) begin
          nextState     = PM_SNOOZE;
          strb.enterSnz = 1'b1;
          strb.srcAdc   = !rxStartDet;
        end
      end
      PM_SNOOZE: begin
        if (snoozeDone) nextState = wakeOk ? PM_RUN : PM_STOP;
      end
      default: nextState = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PM_RUN;
    else       state <= nextState;
  end

  assign cpuClkEn  = (state == PM_RUN);
  assign periClkEn = (state != PM_STOP);
  assign oscEn     = (state != PM_STOP);

endmodule

// File: rtl/pwr_mode_top.sv
module pwr_mode_top
  import pwr_mode_pkg::*;
#(
  parameter int ADC_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             haltInstr,
  input  logic             stopInstr,
  input  logic             extIrq,
  input  logic             wakeTmrIrq,
  input  logic             periphIrq,
  input  logic             rxStartDet,
  input  logic             adcTrig,
  input  logic             snoozeDone,
  input  logic             rxValid,
  input  logic [ADC_W-1:0] adcResult,
  input  logic [ADC_W-1:0] adcLow,
  input  logic [ADC_W-1:0] adcHigh,
  input  logic [1:0]       cmpMode,
  output logic             cmpMatch,
  output logic             cpuClkEn,
  output logic             periClkEn,
  output logic             oscEn
);

  snzStrobe_t strb;
  logic       wakeOk;

  pwr_mode_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .haltInstr(haltInstr), .stopInstr(stopInstr),
    .extIrq(extIrq), .wakeTmrIrq(wakeTmrIrq), .periphIrq(periphIrq),
    .rxStartDet(rxStartDet), .adcTrig(adcTrig), .snoozeDone(snoozeDone),
    .wakeOk(wakeOk), .strb(strb),
    .cpuClkEn(cpuClkEn), .periClkEn(periClkEn), .oscEn(oscEn)
  );

  pwr_mode_cmp #(.ADC_W(ADC_W)) i_cmp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .adcResult(adcResult), .adcLow(adcLow), .adcHigh(adcHigh),
    .cmpMode(cmpMode), .rxValid(rxValid),
    .cmpMatch(cmpMatch), .wakeOk(wakeOk)
  );

endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
  parameter int ADC_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             haltInstr,
  input logic             stopInstr,
  input logic             extIrq,
  input logic             wakeTmrIrq,
  input logic             periphIrq,
  input logic             rxStartDet,
  input logic             adcTrig,
  input logic [ADC_W-1:0] adcResult,
  input logic [ADC_W-1:0] adcLow,
  input logic [ADC_W-1:0] adcHigh,
  input logic [1:0]       cmpMode,
  input logic             cmpMatch,
  input logic             cpuClkEn,
  input logic             periClkEn,
  input logic             oscEn
);

  assert_run_all_on_R1: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |-> (periClkEn && oscEn));

  assert_halt_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && haltInstr && !stopInstr) |=> (!cpuClkEn && periClkEn && oscEn));

  assert_halt_wake_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClkEn && oscEn && periphIrq && !rxStartDet && !adcTrig &&
     !$past(rxStartDet) && !$past(adcTrig) && $past(cpuClkEn)) |=> cpuClkEn);

  assert_stop_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && stopInstr) |=> (!oscEn && !periClkEn && !cpuClkEn));

  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEn && !extIrq && !wakeTmrIrq && !rxStartDet && !adcTrig) |=> !oscEn);

  assert_stop_wake_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEn && (extIrq || wakeTmrIrq)) |=> cpuClkEn);

  assert_snooze_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEn && !extIrq && !wakeTmrIrq && (rxStartDet || adcTrig))
      |=> (oscEn && periClkEn && !cpuClkEn));

  assert_window_inside_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmpMode == 2'b10 && adcResult >= adcLow && adcResult <= adcHigh) |-> cmpMatch);

endmodule

bind pwr_mode_top pwr_mode_chk #(.ADC_W(ADC_W)) i_chk (.*);

// File: tb/test_pwr_mode_top.sv
module test_pwr_mode_top;

  localparam int ADC_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltInstr = 0, stopInstr = 0, extIrq = 0, wakeTmrIrq = 0, periphIrq = 0;
  logic rxStartDet = 0, adcTrig = 0, snoozeDone = 0, rxValid = 0;
  logic [ADC_W-1:0] adcResult = '0, adcLow = '0, adcHigh = '0;
  logic [1:0] cmpMode = 2'b00;
  logic cmpMatch, cpuClkEn, periClkEn, oscEn;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_top #(.ADC_W(ADC_W)) i_pwr_mode_top (.*);

  // {mode, result, low, high, expected}
  localparam logic [32:0] CMP_VEC [12] = '{
    {2'd0, 10'd5,  10'd10, 10'd20, 1'b1},
    {2'd0, 10'd10, 10'd10, 10'd20, 1'b0},
    {2'd1, 10'd21, 10'd10, 10'd20, 1'b1},
    {2'd1, 10'd20, 10'd10, 10'd20, 1'b0},
    {2'd2, 10'd10, 10'd10, 10'd20, 1'b1},
    {2'd2, 10'd20, 10'd10, 10'd20, 1'b1},
    {2'd2, 10'd9,  10'd10, 10'd20, 1'b0},
    {2'd2, 10'd21, 10'd10, 10'd20, 1'b0},
    {2'd3, 10'd9,  10'd10, 10'd20, 1'b1},
    {2'd3, 10'd21, 10'd10, 10'd20, 1'b1},
    {2'd3, 10'd15, 10'd10, 10'd20, 1'b0},
    {2'd3, 10'd10, 10'd10, 10'd20, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    haltInstr = 0; stopInstr = 0; extIrq = 0; wakeTmrIrq = 0; periphIrq = 0;
    rxStartDet = 0; adcTrig = 0; snoozeDone = 0; rxValid = 0;
  endtask

  task automatic chkEn(string tag, logic [2:0] exp);
    checks++;
    if ({cpuClkEn, periClkEn, oscEn} !== exp) begin
      errors++;
      $display("FAIL %s enables actual %b expected %b", tag,
               {cpuClkEn, periClkEn, oscEn}, exp);
    end
  endtask

  task automatic goStop();
    stopInstr = 1; tick(); idle();
  endtask

  initial begin
    @(negedge clk);
    chkEn("R1 during reset", 3'b111);
    tick();
    rstN = 1'b1;
    tick();
    chkEn("R1 after reset", 3'b111);

    // R10 compare table
    foreach (CMP_VEC[i]) begin
      cmpMode   = CMP_VEC[i][32:31];
      adcResult = CMP_VEC[i][30:21];
      adcLow    = CMP_VEC[i][20:11];
      adcHigh   = CMP_VEC[i][10:1];
      #1;
      checks++;
      if (cmpMatch !== CMP_VEC[i][0]) begin
        errors++;
        $display("FAIL R10 vector %0d actual %b expected %b", i, cmpMatch, CMP_VEC[i][0]);
      end
    end

    // R2 / R3
    haltInstr = 1; tick(); idle();
    chkEn("R2 halt entry", 3'b011);
    periphIrq = 1; tick(); idle();
    chkEn("R3 halt wake periphIrq", 3'b111);
    haltInstr = 1; tick(); idle();
    extIrq = 1; tick(); idle();
    chkEn("R3 halt wake extIrq", 3'b111);

    // R4 stop wins over halt
    haltInstr = 1; stopInstr = 1; tick(); idle();
    chkEn("R4 stop entry", 3'b000);

    // R5 ignored inputs in stop
    periphIrq = 1; haltInstr = 1; snoozeDone = 1; rxValid = 1; tick(); idle();
    chkEn("R5 stop ignores", 3'b000);

    // R6 wakes
    extIrq = 1; tick(); idle();
    chkEn("R6 stop wake extIrq", 3'b111);
    goStop();
    wakeTmrIrq = 1; tick(); idle();
    chkEn("R6 stop wake timer", 3'b111);
    goStop();
    extIrq = 1; rxStartDet = 1; tick(); idle();
    chkEn("R6 wake beats snooze", 3'b111);

    // R7 / R8 serial snooze, valid
    goStop();
    rxStartDet = 1; tick(); idle();
    chkEn("R7 snooze entry", 3'b011);
    extIrq = 1; periphIrq = 1; tick(); idle();
    chkEn("R7 snooze ignores irq", 3'b011);
    snoozeDone = 1; rxValid = 1; tick(); idle();
    chkEn("R8 serial valid wakes", 3'b111);

    // R8 serial invalid; rx wins over adc so compare match is irrelevant
    goStop();
    cmpMode = 2'b10; adcLow = 10; adcHigh = 20; adcResult = 15;
    rxStartDet = 1; adcTrig = 1; tick(); idle();
    snoozeDone = 1; rxValid = 0; tick(); idle();
    chkEn("R8 serial invalid back to stop", 3'b000);

    // R9 ADC match
    adcTrig = 1; tick(); idle();
    chkEn("R9 adc snooze entry", 3'b011);
    snoozeDone = 1; tick(); idle();
    chkEn("R9 adc match wakes", 3'b111);

    // R9 ADC no match, rxValid ignored
    goStop();
    adcResult = 30;
    adcTrig = 1; tick(); idle();
    snoozeDone = 1; rxValid = 1; tick(); idle();
    chkEn("R9 adc mismatch to stop", 3'b000);

    // R1 async reset from snooze
    adcTrig = 1; tick(); idle();
    rstN = 1'b0; extIrq = 1; #1;
    chkEn("R1 async reset", 3'b111);
    tick(); rstN = 1'b1; idle(); tick();
    chkEn("R1 run after reset", 3'b111);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule